// File: doc/BRIEF.md
# Byte Serial Port with Handshake and Interrupt

This block is a small peripheral on a parallel host bus. The host picks one of four byte registers with a 2-bit address and either a write strobe or a read strobe. The four registers are data, line status/control, interrupt control and a free scratch byte. A byte written to the data register goes out least-significant bit first on a serial output. Each bit has a one-cycle strobe that marks it as valid. The receive side builds a byte from a serial input: one bit is taken on each rising edge of an input strobe, and the finished byte waits for the host to read it.

Two handshake pairs are provided. The local terminal-ready output is driven from a control bit the host sets. The local clear-to-send output tells the far end that no received byte is waiting. The remote terminal-ready and clear-to-send inputs appear in the status register once they have been synchronised.

A sticky interrupt flag drives the request output. It can be set by three sources:
- a completed received byte;
- either edge of the remote terminal-ready input;
- a rising edge of the remote clear-to-send input.

Each source has its own enable. The host clears the flag by writing zero to it.

Top module: `serlink_port`

## Requirements
- R1: After reset, all four registers read 0x00 (with both remote inputs low), ser_out, ser_out_stb, dtr_out and irq are 0, and cts_out is 1.
- R2: The scratch register (address 11) stores any written byte and returns it on read, with no other effect.
- R3: The line register (address 01) reads as follows: bit0 = stored dtr_out control, bit1 = synchronised dtr_in, bit2 = receive-ready, bit3 = line-clear, bit4 = synchronised cts_in, bits 7..5 = 0. A write stores only bit0, and dtr_out follows that bit.
- R4: A data-register (address 00) write while line-clear is 1 sends the byte LSB first as 8 ser_out_stb pulses, each one cycle long. ser_out is stable in the cycle before each pulse and during it. Line-clear reads 0 while the byte is being shifted.
- R5: Line-clear is 1 only when the transmitter is idle and cts_in (synchronised) is high. A data write while line-clear is 0 is ignored: no strobes are produced.
- R6: The receiver takes the synchronised ser_in on each rising edge of the synchronised ser_in_stb, LSB first. After 8 such edges, the byte is readable at address 00, receive-ready is 1 and cts_out is 0.
- R7: A host read of address 00 clears receive-ready and returns cts_out to 1.
- R8: With interrupt-control bit0 set, a completed received byte sets the active flag (interrupt-control bit3), and irq goes high.
- R9: With interrupt-control bit1 set, a rising or a falling edge of dtr_in sets the active flag.
- R10: With interrupt-control bit2 set, a rising edge of cts_in sets the active flag, and a falling edge does not.
- R11: Writing interrupt control with bit3 = 0 clears the active flag and irq. Writing bit3 = 1 never sets it. A source event in the same cycle as the clearing write wins.
- R12: Interrupt control stores enables in bits 2..0, reads the active flag in bit3, and reads bits 7..4 as 0.
- R13: When a source's enable bit is 0, that source does not set the active flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe (marks the data read that frees the receiver) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| ser_out | output | 1 | Serial transmit bit |
| ser_out_stb | output | 1 | Transmit bit-valid pulse |
| ser_in | input | 1 | Serial receive bit |
| ser_in_stb | input | 1 | Receive bit strobe, one bit per high level |
| dtr_in | input | 1 | Remote terminal-ready |
| dtr_out | output | 1 | Local terminal-ready |
| cts_in | input | 1 | Remote clear-to-send |
| cts_out | output | 1 | Local clear-to-send (no unread byte pending) |
| irq | output | 1 | Interrupt request |

## Verification
A wrong bit count or a wrong shift direction in either shifter shows up as a bad byte on the first transfer. On the transmit side this means a wrong strobe count or a mirrored byte within 17 cycles of the write. On the receive side it means a bad read-back about four cycles after the eighth strobe. A stuck or mis-edged interrupt latch shows on irq three cycles after the input change that should or should not trigger it. This is why each edge direction is driven separately for both handshake inputs. A receive-ready flag that does not clear shows on cts_out on the cycle after the data read.

// File: rtl/serlink_pkg.sv
package serlink_pkg;

    typedef enum logic [1:0] {
        SEL_DATA  = 2'b00,
        SEL_LINE  = 2'b01,
        SEL_INTC  = 2'b10,
        SEL_SCR   = 2'b11
    } reg_sel_e;

    // packed so that bit 0 = receive, bit 1 = terminal-ready, bit 2 = clear-to-send
    typedef struct packed {
        logic cts_en;
        logic dtr_en;
        logic rx_en;
    } irq_en_t;

endpackage

// File: rtl/serlink_sync.sv
module serlink_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] st_d [STAGES];
    logic [WIDTH-1:0] st_q [STAGES];

    always_comb begin
        st_d[0] = d;
        for (int i = 1; i < STAGES; i++) st_d[i] = st_q[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
        end else begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= st_d[i];
        end
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/serlink_tx.sv
module serlink_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    output logic              busy,
    output logic              ser_out,
    output logic              ser_stb
);
    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        logic              busy;
        logic              phase;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
    } tx_st_t;

    tx_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load && !st_q.busy) begin
            st_d.busy  = 1'b1;
            st_d.phase = 1'b0;
            st_d.cnt   = '0;
            st_d.sh    = load_data;
        end else if (st_q.busy) begin
            if (!st_q.phase) begin
                st_d.phase = 1'b1;
            end else begin
                st_d.phase = 1'b0;
                st_d.sh    = st_q.sh >> 1;
                if (st_q.cnt == CNT_W'(DATA_W-1)) st_d.busy = 1'b0;
                else                              st_d.cnt  = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = st_q.busy;
    assign ser_out = st_q.busy & st_q.sh[0];
    assign ser_stb = st_q.busy & st_q.phase;

    p_stb_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_stb |=> !ser_stb);
    p_bit_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ser_stb |-> $stable(ser_out));
    p_start_needs_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(load));
endmodule

// File: rtl/serlink_rx.sv
module serlink_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_s,
    input  logic              stb_s,
    input  logic              take,
    output logic [DATA_W-1:0] data,
    output logic              ready,
    output logic              done
);
    localparam int CNT_W = $clog2(DATA_W);

    typedef struct packed {
        logic              stb_prev;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [DATA_W-1:0] data;
        logic              ready;
    } rx_st_t;

    rx_st_t st_d, st_q;
    logic   rise;

    always_comb begin
        st_d          = st_q;
        done          = 1'b0;
        rise          = stb_s & ~st_q.stb_prev;
        st_d.stb_prev = stb_s;
        if (rise) begin
            st_d.sh = {bit_s, st_q.sh[DATA_W-1:1]};
            if (st_q.cnt == CNT_W'(DATA_W-1)) begin
                st_d.cnt   = '0;
                st_d.data  = {bit_s, st_q.sh[DATA_W-1:1]};
                st_d.ready = 1'b1;
                done       = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
        if (take && !done) st_d.ready = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data  = st_q.data;
    assign ready = st_q.ready;

    p_done_sets_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> ready);
    p_take_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !done) |=> !ready);
endmodule

// File: rtl/serlink_irq.sv
module serlink_irq
    import serlink_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_ctl,
    input  logic [3:0] wdata,
    input  logic       rx_done,
    input  logic       dtr_s,
    input  logic       cts_s,
    output irq_en_t    en,
    output logic       active
);
    typedef struct packed {
        irq_en_t en;
        logic    active;
        logic    dtr_prev;
        logic    cts_prev;
    } irq_st_t;

    irq_st_t st_d, st_q;
    logic    ev;

    always_comb begin
        st_d          = st_q;
        st_d.dtr_prev = dtr_s;
        st_d.cts_prev = cts_s;
        ev = (st_q.en.rx_en  & rx_done)
           | (st_q.en.dtr_en & (dtr_s ^ st_q.dtr_prev))
           | (st_q.en.cts_en & cts_s & ~st_q.cts_prev);
        if (wr_ctl) begin
            st_d.en = irq_en_t'(wdata[2:0]);
            if (!wdata[3]) st_d.active = 1'b0;
        end
        if (ev) st_d.active = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en     = st_q.en;
    assign active = st_q.active;

    p_dtr_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.en.dtr_en && (dtr_s != st_q.dtr_prev)) |=> active);
    p_cts_fall_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cts_s && st_q.cts_prev && !wr_ctl && !rx_done && (dtr_s == st_q.dtr_prev))
        |=> $stable(active));
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !wdata[3] && !ev) |=> !active);
endmodule

// File: rtl/serlink_port.sv
module serlink_port
    import serlink_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              ser_out,
    output logic              ser_out_stb,
    input  logic              ser_in,
    input  logic              ser_in_stb,
    input  logic              dtr_in,
    output logic              dtr_out,
    input  logic              cts_in,
    output logic              cts_out,
    output logic              irq
);
    localparam int PAD_LINE = DATA_W - 5;
    localparam int PAD_INTC = DATA_W - 4;

    typedef struct packed {
        logic              dtr_ctl;
        logic [DATA_W-1:0] scratch;
    } top_st_t;

    top_st_t     st_d, st_q;
    reg_sel_e    sel;
    logic [3:0]  sync_q;
    logic        bit_s, stb_s, dtr_s, cts_s;
    logic        tx_busy, line_clear, tx_load;
    logic        rx_take, rx_ready, rx_done;
    logic [DATA_W-1:0] rx_data;
    irq_en_t     irq_en;
    logic        irq_active;

    assign sel = reg_sel_e'(addr);

    serlink_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cts_in, dtr_in, ser_in_stb, ser_in}),
        .q    (sync_q)
    );
    assign {cts_s, dtr_s, stb_s, bit_s} = sync_q;

    assign line_clear = ~tx_busy & cts_s;
    assign tx_load    = wr_en & (sel == SEL_DATA) & line_clear;
    assign rx_take    = rd_en & (sel == SEL_DATA);

    serlink_tx #(.DATA_W(DATA_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tx_load),
        .load_data(wdata),
        .busy     (tx_busy),
        .ser_out  (ser_out),
        .ser_stb  (ser_out_stb)
    );

    serlink_rx #(.DATA_W(DATA_W)) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .bit_s(bit_s),
        .stb_s(stb_s),
        .take (rx_take),
        .data (rx_data),
        .ready(rx_ready),
        .done (rx_done)
    );

    serlink_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_ctl (wr_en & (sel == SEL_INTC)),
        .wdata  (wdata[3:0]),
        .rx_done(rx_done),
        .dtr_s  (dtr_s),
        .cts_s  (cts_s),
        .en     (irq_en),
        .active (irq_active)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (sel == SEL_LINE) st_d.dtr_ctl = wdata[0];
            if (sel == SEL_SCR)  st_d.scratch = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (sel)
            SEL_DATA: rdata = rx_data;
            SEL_LINE: rdata = {{PAD_LINE{1'b0}}, cts_s, line_clear, rx_ready, dtr_s, st_q.dtr_ctl};
            SEL_INTC: rdata = {{PAD_INTC{1'b0}}, irq_active, irq_en};
            default:  rdata = st_q.scratch;
        endcase
    end

    assign dtr_out = st_q.dtr_ctl;
    assign cts_out = ~rx_ready;
    assign irq     = irq_active;

    p_blocked_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DATA && !tx_busy && !cts_s) |=> !tx_busy);
    p_cts_out_after_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_take && !rx_done) |=> cts_out);
endmodule

// File: tb/sim_serlink_port.sv
module sim_serlink_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'b00;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       ser_out, ser_out_stb, dtr_out, cts_out, irq;
    logic       ser_in = 1'b0, ser_in_stb = 1'b0, dtr_in = 1'b0, cts_in = 1'b0;

    int   checks = 0, failures = 0;
    bit   finished = 1'b0;
    int   nstb = 0;
    logic [7:0] cap = 8'h00;

    always #5 clk = ~clk;

    serlink_port u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ser_out(ser_out), .ser_out_stb(ser_out_stb),
        .ser_in(ser_in), .ser_in_stb(ser_in_stb), .dtr_in(dtr_in), .dtr_out(dtr_out),
        .cts_in(cts_in), .cts_out(cts_out), .irq(irq)
    );

    // transmit monitor: one sample per strobe cycle, assembled LSB first
    always @(negedge clk) begin
        if (ser_out_stb) begin
            cap  <= {ser_out, cap[7:1]};
            nstb <= nstb + 1;
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ser_in = v[i]; ser_in_stb = 1'b1;
            repeat (2) @(negedge clk);
            ser_in_stb = 1'b0;
            @(negedge clk);
        end
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        int s0;
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            bus_read(a[1:0], r);
            check("R1 reg after reset", r, 8'h00);
        end
        check("R1 outputs", {3'b0, ser_out, ser_out_stb, dtr_out, irq, cts_out}, 8'h01);

        // R2 scratch sweep
        for (int v = 0; v < 256; v += 17) begin
            bus_write(2'b11, v[7:0]);
            bus_read(2'b11, r);
            check("R2 scratch", r, v[7:0]);
        end
        bus_read(2'b10, r);
        check("R2 no side effect on interrupt control", r, 8'h00);

        // R3 line register map
        bus_write(2'b01, 8'hFF);
        check("R3 dtr_out", {7'b0, dtr_out}, 8'h01);
        dtr_in = 1'b1; cts_in = 1'b1;
        wait_cyc(4);
        bus_read(2'b01, r);
        check("R3 line status", r, 8'h1B);
        bus_write(2'b01, 8'hFE);
        check("R3 dtr_out cleared", {7'b0, dtr_out}, 8'h00);
        bus_read(2'b01, r);
        check("R3 line status bit0 low", r, 8'h1A);

        // R4 transmit sweep over all bytes
        for (int v = 0; v < 256; v++) begin
            s0 = nstb;
            bus_write(2'b00, v[7:0]);
            bus_read(2'b01, r);
            check("R4 line-clear low while shifting", {7'b0, r[3]}, 8'h00);
            wait_cyc(18);
            check("R4 strobe count", 8'(nstb - s0), 8'd8);
            check("R4 byte LSB first", cap, v[7:0]);
        end

        // R5 write while busy is ignored
        s0 = nstb;
        bus_write(2'b00, 8'hC3);
        bus_write(2'b00, 8'h3C);
        wait_cyc(40);
        check("R5 busy write ignored count", 8'(nstb - s0), 8'd8);
        check("R5 busy write ignored byte", cap, 8'hC3);
        // R5 write with cts low is ignored
        cts_in = 1'b0;
        wait_cyc(4);
        bus_read(2'b01, r);
        check("R5 line-clear low with cts low", {7'b0, r[3]}, 8'h00);
        s0 = nstb;
        bus_write(2'b00, 8'h5A);
        wait_cyc(20);
        check("R5 cts-low write ignored", 8'(nstb - s0), 8'd0);

        // R6/R7/R13 receive sweep, interrupts disabled
        for (int v = 0; v < 256; v++) begin
            send_byte(v[7:0]);
            wait_cyc(4);
            bus_read(2'b01, r);
            check("R6 ready bit", {7'b0, r[2]}, 8'h01);
            check("R6 cts_out low", {7'b0, cts_out}, 8'h00);
            bus_read(2'b00, r);
            check("R6 received byte", r, v[7:0]);
            check("R7 cts_out restored", {7'b0, cts_out}, 8'h01);
            bus_read(2'b01, r);
            check("R7 ready cleared", {7'b0, r[2]}, 8'h00);
        end
        check("R13 no irq with enables off", {7'b0, irq}, 8'h00);

        // R12 / R11 interrupt control map, writing 1 to active does not set it
        bus_write(2'b10, 8'hFF);
        bus_read(2'b10, r);
        check("R12 interrupt control read", r, 8'h07);
        check("R11 write of 1 does not set", {7'b0, irq}, 8'h00);

        // R8 receive interrupt
        bus_write(2'b10, 8'h01);
        send_byte(8'h96);
        wait_cyc(6);
        check("R8 irq on receive", {7'b0, irq}, 8'h01);
        bus_read(2'b10, r);
        check("R8 active flag", r, 8'h09);
        bus_read(2'b00, r);
        check("R8 byte", r, 8'h96);
        bus_write(2'b10, 8'h01);
        check("R11 clear by write", {7'b0, irq}, 8'h00);

        // R9 terminal-ready both edges
        bus_write(2'b10, 8'h02);
        dtr_in = 1'b0;
        wait_cyc(5);
        check("R9 irq on dtr fall", {7'b0, irq}, 8'h01);
        bus_write(2'b10, 8'h02);
        check("R11 clear after dtr", {7'b0, irq}, 8'h00);
        dtr_in = 1'b1;
        wait_cyc(5);
        check("R9 irq on dtr rise", {7'b0, irq}, 8'h01);
        bus_write(2'b10, 8'h00);

        // R10 clear-to-send rising only
        bus_write(2'b10, 8'h04);
        cts_in = 1'b1;
        wait_cyc(5);
        check("R10 irq on cts rise", {7'b0, irq}, 8'h01);
        bus_write(2'b10, 8'h04);
        cts_in = 1'b0;
        wait_cyc(5);
        check("R10 no irq on cts fall", {7'b0, irq}, 8'h00);
        bus_write(2'b10, 8'h00);

        // R13 edge with enable off
        dtr_in = 1'b0;
        wait_cyc(5);
        check("R13 dtr edge with enable off", {7'b0, irq}, 8'h00);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule